// File: doc/BRIEF.md
# Slot-Scheduled Lookup Engine Controller

This controller lets a pool of identical lookup engines share one single-port memory. Each engine makes exactly one memory read per fixed access period. The controller keeps a timing wheel with one slot per cycle of that period, and each running engine owns exactly one slot. A destination address is taken from a first-word-fall-through input FIFO only when a free, enabled engine exists and the slot that engine's first read will land in is unclaimed. The engine then owns that slot until it reports completion.

In every cycle the memory port carries the read of the engine that owns the current slot. Finished results are held per engine and carry a sequence tag. They are pushed into the output FIFO strictly in the order the addresses were taken. The engines are outside this block. The controller sees each engine only through its start strobe, its read request and address, and its done pulse and result.

Top module: `lookup_wheel_sched`

## Requirements
- R1: While rst_n is low, in_pop, eng_start, mem_rd and out_push are all 0.
- R2: The wheel index is 0 in the first cycle after reset is released and advances by one each cycle modulo P. A start in slot s claims slot (s+LAT) mod P. A start is allowed only if that slot is unclaimed, so two engine reads never fall in the same cycle.
- R3: in_pop is 1 exactly when all of the following hold: the input is non-empty, out_full is 0, at least one enabled engine is idle, and the target slot is unclaimed.
- R4: On a pop, eng_start is one-hot and selects the lowest-numbered enabled idle engine (bit i of eng_start is engine i). start_addr carries the popped address.
- R5: mem_rd is 1 in a cycle exactly when the engine that owns the current slot raises its read request. mem_addr is then that engine's MW-bit field of rd_addr, where engine i occupies bits [i*MW +: MW].
- R6: Each result is pushed exactly once. Results appear on out_data in the order their addresses were popped, even when engines finish out of order. Engine i's result occupies bits [i*RW +: RW] of result.
- R7: out_push is never 1 while out_full is 1. A ready result waits until out_full falls.
- R8: A done pulse frees the engine's slot from the next cycle on. The engine's result becomes eligible for output from the next cycle on.
- R9: An engine whose bit in eng_en is 0 is never started. Clearing the bit does not disturb a lookup already in flight.
- R10: An engine stays busy until its result has been pushed, and it can be started again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_en | input | NE | Per-engine enable mask |
| in_empty | input | 1 | Input FIFO is empty |
| in_data | input | AW | Head of the input FIFO |
| in_pop | output | 1 | Pop the input FIFO |
| eng_start | output | NE | One-hot engine start strobe |
| start_addr | output | AW | Address handed to the started engine |
| rd_req | input | NE | Per-engine read request |
| rd_addr | input | NE*MW | Per-engine read addresses, packed |
| eng_done | input | NE | Per-engine completion pulse |
| result | input | NE*RW | Per-engine results, packed |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | MW | Memory read address |
| out_full | input | 1 | Output FIFO is full |
| out_push | output | 1 | Push into the output FIFO |
| out_data | output | RW | Result pushed into the output FIFO |

## Verification
Suppose a slot claim is wrongly recorded or released. In the very cycle the next start is decided, in_pop will differ from a wheel model rebuilt from the engines' own start and done times, and two stub engines will raise read requests in the same cycle one period later. A corrupted sequence tag or holding register shows up as a missing, duplicated or out-of-order value on out_data as soon as the affected result is due. An engine that is freed too early or too late changes which engine eng_start selects on the next pop. Because every output is compared against the model in every cycle, each of these faults appears within one access period of its cause.

// File: rtl/lookup_wheel_sched.sv
module lookup_wheel_sched #(
  parameter int NE  = 4,
  parameter int P   = 8,
  parameter int LAT = 2,
  parameter int AW  = 32,
  parameter int MW  = 18,
  parameter int RW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NE-1:0]    eng_en,
  input  logic             in_empty,
  input  logic [AW-1:0]    in_data,
  output logic             in_pop,
  output logic [NE-1:0]    eng_start,
  output logic [AW-1:0]    start_addr,
  input  logic [NE-1:0]    rd_req,
  input  logic [NE*MW-1:0] rd_addr,
  input  logic [NE-1:0]    eng_done,
  input  logic [NE*RW-1:0] result,
  output logic             mem_rd,
  output logic [MW-1:0]    mem_addr,
  input  logic             out_full,
  output logic             out_push,
  output logic [RW-1:0]    out_data
);
  localparam int SW = (P > 1) ? $clog2(P) : 1;
  localparam int EW = (NE > 1) ? $clog2(NE) : 1;
  localparam int TW = $clog2(NE) + 1;

  logic [SW-1:0] wheel;
  logic [P-1:0]  slot_busy;
  logic [EW-1:0] slot_own [P];
  logic [NE-1:0] eng_busy, res_vld;
  logic [TW-1:0] eng_tag [NE];
  logic [RW-1:0] res_q [NE];
  logic [TW-1:0] in_seq, out_seq;

  logic [SW:0]   tsum;
  logic [SW-1:0] tgt;
  assign tsum = {1'b0, wheel} + (SW+1)'(LAT);
  assign tgt  = (tsum >= (SW+1)'(P)) ? SW'(tsum - (SW+1)'(P)) : SW'(tsum);

  logic [NE-1:0] free_e;
  logic          pick_ok;
  logic [EW-1:0] pick;
  assign free_e = eng_en & ~eng_busy;

  always_comb begin
    pick_ok = 1'b0;
    pick    = '0;
    for (int i = NE-1; i >= 0; i--)
      if (free_e[i]) begin
        pick_ok = 1'b1;
        pick    = EW'(i);
      end
  end

  logic can_go;
  assign can_go     = rst_n & ~in_empty & ~out_full & pick_ok & ~slot_busy[tgt];
  assign in_pop     = can_go;
  assign eng_start  = can_go ? (NE'(1) << pick) : '0;
  assign start_addr = in_data;

  logic [EW-1:0] owner;
  assign owner    = slot_own[wheel];
  assign mem_rd   = rst_n & slot_busy[wheel] & rd_req[owner];
  assign mem_addr = rd_addr[int'(owner)*MW +: MW];

  logic          hit;
  logic [EW-1:0] hsel;
  always_comb begin
    hit  = 1'b0;
    hsel = '0;
    for (int i = 0; i < NE; i++)
      if (res_vld[i] && eng_tag[i] == out_seq) begin
        hit  = 1'b1;
        hsel = EW'(i);
      end
  end

  assign out_push = rst_n & hit & ~out_full;
  assign out_data = res_q[hsel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wheel     <= '0;
      slot_busy <= '0;
      eng_busy  <= '0;
      res_vld   <= '0;
      in_seq    <= '0;
      out_seq   <= '0;
      for (int s = 0; s < P; s++) slot_own[s] <= '0;
      for (int e = 0; e < NE; e++) begin
        eng_tag[e] <= '0;
        res_q[e]   <= '0;
      end
    end else begin
      wheel <= (wheel == SW'(P-1)) ? '0 : wheel + 1'b1;
      for (int s = 0; s < P; s++)
        if (slot_busy[s] && eng_done[slot_own[s]]) slot_busy[s] <= 1'b0;
      for (int e = 0; e < NE; e++)
        if (eng_done[e] && eng_busy[e]) begin
          res_vld[e] <= 1'b1;
          res_q[e]   <= result[e*RW +: RW];
        end
      if (out_push) begin
        res_vld[hsel]  <= 1'b0;
        eng_busy[hsel] <= 1'b0;
        out_seq        <= out_seq + 1'b1;
      end
      if (can_go) begin
        slot_busy[tgt] <= 1'b1;
        slot_own[tgt]  <= pick;
        eng_busy[pick] <= 1'b1;
        eng_tag[pick]  <= in_seq;
        in_seq         <= in_seq + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lookup_wheel_sched_chk.sv
module lookup_wheel_sched_chk #(
  parameter int NE = 4,
  parameter int P  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_empty,
  input logic          out_full,
  input logic          in_pop,
  input logic          out_push,
  input logic          mem_rd,
  input logic [NE-1:0] eng_start,
  input logic [NE-1:0] eng_en,
  input logic [NE-1:0] rd_req,
  input logic [((P > 1) ? $clog2(P) : 1)-1:0] wheel
);
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!in_pop && !out_push && !mem_rd && eng_start == '0);
    end
  end

  p_wheel_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (int'(wheel) == ((int'($past(wheel)) == P-1) ? 0 : int'($past(wheel)) + 1)));

  p_pop_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> (!in_empty && !out_full));

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pop |-> ($countones(eng_start) == 1));

  p_start_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start));

  p_mem_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (rd_req != '0));

  p_no_push_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_full |-> !out_push);

  p_start_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start != '0) |-> ((eng_start & ~eng_en) == '0));
endmodule

bind lookup_wheel_sched lookup_wheel_sched_chk #(.NE(NE), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_empty(in_empty), .out_full(out_full),
  .in_pop(in_pop), .out_push(out_push), .mem_rd(mem_rd),
  .eng_start(eng_start), .eng_en(eng_en), .rd_req(rd_req), .wheel(wheel)
);

// File: tb/lookup_wheel_sched_bench.sv
module lookup_wheel_sched_bench;
  localparam int CLK_T = 10;
  localparam int NE = 4, P = 8, LAT = 2, AW = 16, MW = 12, RW = 16;
  localparam int N = 150;
  localparam int WD = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] eng_en = '1;
  logic in_empty = 1'b1;
  logic [AW-1:0] in_data = '0;
  logic in_pop;
  logic [NE-1:0] eng_start;
  logic [AW-1:0] start_addr;
  logic [NE-1:0] rd_req = '0;
  logic [NE*MW-1:0] rd_addr = '0;
  logic [NE-1:0] eng_done = '0;
  logic [NE*RW-1:0] result = '0;
  logic mem_rd;
  logic [MW-1:0] mem_addr;
  logic out_full = 1'b0;
  logic out_push;
  logic [RW-1:0] out_data;

  always #(CLK_T/2) clk = ~clk;

  lookup_wheel_sched #(.NE(NE), .P(P), .LAT(LAT), .AW(AW), .MW(MW), .RW(RW)) u_lookup_wheel_sched (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .in_empty(in_empty), .in_data(in_data),
    .in_pop(in_pop), .eng_start(eng_start), .start_addr(start_addr), .rd_req(rd_req),
    .rd_addr(rd_addr), .eng_done(eng_done), .result(result), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .out_full(out_full), .out_push(out_push), .out_data(out_data));

  int checks = 0, failures = 0;
  int st_busy[NE], st_t[NE], st_addr[NE], st_k[NE], st_seq[NE], st_slot[NE], st_sb[NE], st_dat[NE];
  int qrd = 0, nxt = 0;

  function automatic int item_addr(int i); return (i*97 + 13) & 16'hFFFF; endfunction
  function automatic int res_of(int a); return (a*5 + 1) & 16'hFFFF; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    for (int e = 0; e < NE; e++) begin
      st_busy[e] = 0; st_sb[e] = 0; st_t[e] = 0; st_addr[e] = 0;
      st_k[e] = 0; st_seq[e] = 0; st_slot[e] = 0; st_dat[e] = 0;
    end
    in_empty = 1'b0; rd_req = '1; out_full = 1'b0;
    for (int r = 0; r < 3; r++) begin
      @(negedge clk); #1;
      chk(!in_pop && eng_start == '0, "R1 pop/start in reset", int'(eng_start), 0);
      chk(!mem_rd && !out_push, "R1 mem/push in reset", int'(mem_rd), 0);
    end
    for (int c = 0; ; c++) begin
      int tgt, pick, pe, k, sl;
      bit exp_pop, sbusy, exp_push, any_free;
      logic [NE-1:0] exp_start;
      @(negedge clk);
      rst_n = 1'b1;
      if (nxt >= N) break;
      if (c >= WD) begin
        chk(1'b0, "R6 watchdog", nxt, N);
        break;
      end
      eng_en   = (c < 300) ? 4'hF : (c < 600) ? 4'h5 : (c < 800) ? 4'h8 : 4'hF;
      out_full = ((c / 7) % 5 == 0);
      in_empty = (qrd >= N) || (c % 11 == 3);
      in_data  = AW'(item_addr(qrd < N ? qrd : 0));
      rd_req = '0; eng_done = '0;
      for (int e = 0; e < NE; e++) begin
        int d;
        d = c - st_t[e] - LAT;
        if (st_busy[e] && st_sb[e] && d >= 0 && d % P == 0 && d / P < st_k[e]) begin
          rd_req[e] = 1'b1;
          rd_addr[e*MW +: MW] = MW'(st_addr[e] + 3*(d / P));
        end
        if (st_busy[e] && st_sb[e] && c == st_dat[e]) begin
          eng_done[e] = 1'b1;
          result[e*RW +: RW] = RW'(res_of(st_addr[e]));
        end
      end
      #1;
      tgt = (c + LAT) % P;
      sbusy = 0;
      for (int e = 0; e < NE; e++) if (st_sb[e] && st_slot[e] == tgt) sbusy = 1;
      pick = -1;
      for (int e = NE-1; e >= 0; e--) if (eng_en[e] && !st_busy[e]) pick = e;
      any_free = (pick >= 0);
      exp_pop = !in_empty && !out_full && any_free && !sbusy;
      chk(in_pop == exp_pop, "R3 pop condition (R2 slot claim)", int'(in_pop), int'(exp_pop));
      exp_start = exp_pop ? (NE'(1) << pick) : '0;
      chk(eng_start == exp_start, "R4 engine choice", int'(eng_start), int'(exp_start));
      chk((eng_start & ~eng_en) == '0, "R9 disabled engine started", int'(eng_start), 0);
      if (exp_pop) chk(start_addr == in_data, "R4 start address", int'(start_addr), int'(in_data));
      chk($countones(rd_req) <= 1, "R2 read collision", $countones(rd_req), 1);
      chk(mem_rd == (rd_req != '0), "R5 mem_rd", int'(mem_rd), int'(rd_req != '0));
      for (int e = 0; e < NE; e++)
        if (rd_req[e]) chk(mem_addr == rd_addr[e*MW +: MW], "R5 mem_addr", int'(mem_addr), int'(rd_addr[e*MW +: MW]));
      pe = -1;
      for (int e = 0; e < NE; e++)
        if (st_busy[e] && st_seq[e] == nxt && st_dat[e] < c && !st_sb[e]) pe = e;
      exp_push = (pe >= 0) && !out_full;
      chk(out_push == exp_push, out_full ? "R7 push while full" : "R8 push timing", int'(out_push), int'(exp_push));
      if (exp_push) chk(out_data == RW'(res_of(item_addr(nxt))), "R6 result order", int'(out_data), res_of(item_addr(nxt)));
      if (exp_push) begin
        st_busy[pe] = 0;
        nxt++;
      end
      for (int e = 0; e < NE; e++) if (eng_done[e]) st_sb[e] = 0;
      if (exp_pop) begin
        k = (item_addr(qrd) % 3) + 1;
        sl = tgt;
        st_busy[pick] = 1; st_sb[pick] = 1; st_t[pick] = c;
        st_addr[pick] = item_addr(qrd); st_k[pick] = k; st_seq[pick] = qrd;
        st_slot[pick] = sl; st_dat[pick] = c + LAT + (k-1)*P + 1;
        qrd++;
      end
    end
    chk(nxt == N, "R6 all results delivered", nxt, N);
    chk(qrd == N, "R10 all inputs consumed", qrd, N);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule